// File: doc/BRIEF.md
# Serial Register-Access Slave

This block is a four-wire serial slave that lets a host read and write a bank of 8-bit registers. The host pulls chip select low and sends a command byte. Its top bit selects read (1) or write (0), and its lower seven bits give the register address. One data byte follows. All bits travel most significant bit first. The block samples SDI on rising SCK edges and changes SDO only after falling edges. It oversamples SCK, chip select and SDI in its own clock domain, so SCK has to run well below that clock.

On the register side, the block presents an address, a one-cycle write strobe with write data, and a one-cycle read strobe. The bank must answer the read strobe with combinational read data in the same cycle, and it must accept every write strobe in the cycle it is raised. The bank port has no back-pressure. A read copies the addressed register at the end of the command byte and shifts that copy out during the data phase. Every committed write raises `busy` for a window counted in ticks of a slow clock. Any access whose command byte completes inside that window is discarded, and a sticky error flag is set.

Top module: `spi_regs_slave`

## Requirements
- R1: After reset, `busy`, `err`, `sdo_oe`, `reg_wr_en` and `reg_rd_en` are all 0.
- R2: A write frame (command bit 7 = 0, address in bits 6:0, then one data byte) produces exactly one `reg_wr_en` pulse carrying that address and data, on the 16th rising SCK edge. A write strobe and a read strobe are never high together.
- R3: SDI is sampled on rising SCK edges. While SDO is driven, its value changes only while SCK is low, that is, after a falling edge.
- R4: A read frame (command bit 7 = 1) pulses `reg_rd_en` once at the end of the command byte and captures the addressed value. That value is shifted out MSB first over the eight data clocks. SDI has no effect during the read data phase.
- R5: `sdo_oe` stays 0 for the whole of a write frame and outside the data phase of an accepted read.
- R6: Raising chip select before the 16th rising SCK edge aborts the frame. No write strobe is produced, and `busy` stays 0.
- R7: `busy` rises in the cycle after a write strobe and stays high until BUSY_TICKS (default 3) `slow_tick` pulses have been counted after the commit. It falls in the cycle after the last of those ticks.
- R8: An access whose command byte completes while `busy` is high is dropped. No strobe is produced, SDO is not driven, and `err` is set.
- R9: Once set, `err` stays 1 until reset.
- R10: SCK edges after the 16th in a frame are ignored. A write with extra clocks commits once, with the first data byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used for oversampling |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock from the host |
| scs_n | input | 1 | Chip select, active low |
| sdi | input | 1 | Serial data from the host |
| sdo | output | 1 | Serial data to the host |
| sdo_oe | output | 1 | SDO drive enable; 0 means high impedance |
| slow_tick | input | 1 | One-cycle pulse per slow-clock period |
| reg_addr | output | 7 | Register address for the bank |
| reg_wr_en | output | 1 | One-cycle write strobe |
| reg_wr_data | output | 8 | Write data |
| reg_rd_en | output | 1 | One-cycle read strobe |
| reg_rd_data | input | 8 | Combinational read data from the bank |
| busy | output | 1 | Post-write wait window active |
| err | output | 1 | Sticky flag for a dropped access |

## Verification
The bench checks that SDO never turns on during a write frame. A design that decodes the direction bit late would leak a driven bit onto the shared line. It cuts a frame short after thirteen clocks, where a design that commits on a byte count rather than a full frame would write garbage. It also clocks past sixteen bits, where a design that does not stop would re-commit or shift the data. The busy window is measured tick by tick: falling one tick early lets a host access land too soon, and falling one tick late stalls it. A read and a write issued inside the window must both vanish while the error flag latches. Two reads with opposite SDI patterns must return the same byte, which exposes any design that lets SDI leak into the read path.

// File: rtl/spi_regs_pkg.sv
package spi_regs_pkg;
  typedef enum logic [1:0] {
    PH_CMD  = 2'd0,
    PH_RD   = 2'd1,
    PH_WR   = 2'd2,
    PH_SKIP = 2'd3
  } frame_ph_e;
endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
  parameter int          W       = 3,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] pipe [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) pipe[s] <= RST_VAL;
        else        pipe[s] <= din;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) pipe[s] <= RST_VAL;
        else        pipe[s] <= pipe[s-1];
    end
  end

  assign dout = pipe[STAGES-1];
endmodule

// File: rtl/spi_busy_timer.sv
module spi_busy_timer #(
  parameter int TICKS = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic tick,
  output logic busy
);
  localparam int CW = (TICKS < 2) ? 1 : $clog2(TICKS);
  logic [CW-1:0] seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      seen <= '0;
    end else if (start) begin
      busy <= 1'b1;
      seen <= '0;
    end else if (busy && tick) begin
      if (seen == CW'(TICKS - 1)) begin
        busy <= 1'b0;
        seen <= '0;
      end else begin
        seen <= seen + 1'b1;
      end
    end
  end
endmodule

// File: rtl/spi_frame_ctl.sv
module spi_frame_ctl
  import spi_regs_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_s,
  input  logic              cs_act,
  input  logic              sdi_s,
  input  logic              busy,
  input  logic [DATA_W-1:0] reg_rd_data,
  output logic [ADDR_W-1:0] reg_addr,
  output logic              reg_wr_en,
  output logic [DATA_W-1:0] reg_wr_data,
  output logic              reg_rd_en,
  output logic              sdo,
  output logic              sdo_oe,
  output logic              drop
);
  localparam int CMD_W  = ADDR_W + 1;
  localparam int FRAME  = CMD_W + DATA_W;
  localparam int CNT_W  = $clog2(FRAME + 1);
  localparam int SH_W   = (CMD_W > DATA_W) ? CMD_W : DATA_W;

  frame_ph_e         ph;
  logic              sck_prev;
  logic [CNT_W-1:0]  cnt;
  logic [SH_W-1:0]   sh;
  logic [DATA_W-1:0] rd_sh;
  logic              rise, fall;
  logic [CMD_W-1:0]  cmd_now;
  logic [DATA_W-1:0] dat_now;

  assign rise    = sck_s & ~sck_prev;
  assign fall    = ~sck_s & sck_prev;
  assign cmd_now = {sh[CMD_W-2:0], sdi_s};
  assign dat_now = {sh[DATA_W-2:0], sdi_s};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph          <= PH_CMD;
      sck_prev    <= 1'b0;
      cnt         <= '0;
      sh          <= '0;
      rd_sh       <= '0;
      reg_addr    <= '0;
      reg_wr_en   <= 1'b0;
      reg_wr_data <= '0;
      reg_rd_en   <= 1'b0;
      drop        <= 1'b0;
    end else begin
      sck_prev  <= sck_s;
      reg_wr_en <= 1'b0;
      reg_rd_en <= 1'b0;
      drop      <= 1'b0;
      if (!cs_act) begin
        ph  <= PH_CMD;
        cnt <= '0;
      end else begin
        if (rise && ph != PH_SKIP) begin
          sh  <= {sh[SH_W-2:0], sdi_s};
          cnt <= cnt + 1'b1;
        end
        unique case (ph)
          PH_CMD: if (rise && cnt == CNT_W'(CMD_W - 1)) begin
            reg_addr <= cmd_now[ADDR_W-1:0];
            if (busy) begin
              ph   <= PH_SKIP;
              drop <= 1'b1;
            end else if (cmd_now[CMD_W-1]) begin
              ph        <= PH_RD;
              reg_rd_en <= 1'b1;
            end else begin
              ph <= PH_WR;
            end
          end
          PH_RD: begin
            if (reg_rd_en)
              rd_sh <= reg_rd_data;
            else if (fall && cnt > CNT_W'(CMD_W))
              rd_sh <= {rd_sh[DATA_W-2:0], 1'b0};
            if (rise && cnt == CNT_W'(FRAME - 1))
              ph <= PH_SKIP;
          end
          PH_WR: if (rise && cnt == CNT_W'(FRAME - 1)) begin
            reg_wr_en   <= 1'b1;
            reg_wr_data <= dat_now;
            ph          <= PH_SKIP;
          end
          default: ;
        endcase
      end
    end
  end

  assign sdo_oe = (ph == PH_RD) && !reg_rd_en;
  assign sdo    = rd_sh[DATA_W-1];
endmodule

// File: rtl/spi_regs_slave.sv
module spi_regs_slave #(
  parameter int ADDR_W     = 7,
  parameter int DATA_W     = 8,
  parameter int BUSY_TICKS = 3,
  parameter int SYNC_STG   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck,
  input  logic              scs_n,
  input  logic              sdi,
  output logic              sdo,
  output logic              sdo_oe,
  input  logic              slow_tick,
  output logic [ADDR_W-1:0] reg_addr,
  output logic              reg_wr_en,
  output logic [DATA_W-1:0] reg_wr_data,
  output logic              reg_rd_en,
  input  logic [DATA_W-1:0] reg_rd_data,
  output logic              busy,
  output logic              err
);
  logic [2:0] pins_s;
  logic       drop;

  spi_in_sync #(.W(3), .STAGES(SYNC_STG), .RST_VAL(3'b010)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({sdi, scs_n, sck}),
    .dout (pins_s)
  );

  spi_frame_ctl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_frame (
    .clk        (clk),
    .rst_n      (rst_n),
    .sck_s      (pins_s[0]),
    .cs_act     (~pins_s[1]),
    .sdi_s      (pins_s[2]),
    .busy       (busy),
    .reg_rd_data(reg_rd_data),
    .reg_addr   (reg_addr),
    .reg_wr_en  (reg_wr_en),
    .reg_wr_data(reg_wr_data),
    .reg_rd_en  (reg_rd_en),
    .sdo        (sdo),
    .sdo_oe     (sdo_oe),
    .drop       (drop)
  );

  spi_busy_timer #(.TICKS(BUSY_TICKS)) u_busy (
    .clk  (clk),
    .rst_n(rst_n),
    .start(reg_wr_en),
    .tick (slow_tick),
    .busy (busy)
  );

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)    err <= 1'b0;
    else if (drop) err <= 1'b1;
endmodule

// File: rtl/spi_regs_chk.sv
module spi_regs_chk (
  input logic clk,
  input logic rst_n,
  input logic reg_wr_en,
  input logic reg_rd_en,
  input logic busy,
  input logic err,
  input logic sdo_oe,
  input logic slow_tick
);
  AST_WR_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en |-> !busy); // R8
  AST_BUSY_AFTER_WR: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en |=> busy); // R7
  AST_BUSY_ROSE_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(reg_wr_en)); // R7
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !slow_tick && !reg_wr_en) |=> busy); // R7
  AST_NO_OE_ON_WR: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en |-> !sdo_oe); // R5
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr_en && reg_rd_en)); // R2
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err); // R9
endmodule

bind spi_regs_slave spi_regs_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .reg_wr_en(reg_wr_en),
  .reg_rd_en(reg_rd_en),
  .busy     (busy),
  .err      (err),
  .sdo_oe   (sdo_oe),
  .slow_tick(slow_tick)
);

// File: tb/sim_spi_regs_slave.sv
`timescale 1ns/1ps
module sim_spi_regs_slave;
  localparam int HALF = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sck = 1'b0, scs_n = 1'b1, sdi = 1'b0, slow_tick = 1'b0;
  logic       sdo, sdo_oe, reg_wr_en, reg_rd_en, busy, err;
  logic [6:0] reg_addr;
  logic [7:0] reg_wr_data, reg_rd_data;

  int tests = 0, fails = 0;
  int wr_cnt = 0, rd_cnt = 0;
  logic [6:0] last_addr;
  logic [7:0] last_data;
  logic [7:0] bank [128];
  logic in_wr = 1'b0, oe_bad = 1'b0, edge_bad = 1'b0, prev_sdo = 1'b0, prev_oe = 1'b0;

  always #2.5 clk = ~clk;

  spi_regs_slave u0 (
    .clk(clk), .rst_n(rst_n), .sck(sck), .scs_n(scs_n), .sdi(sdi),
    .sdo(sdo), .sdo_oe(sdo_oe), .slow_tick(slow_tick),
    .reg_addr(reg_addr), .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
    .reg_rd_en(reg_rd_en), .reg_rd_data(reg_rd_data), .busy(busy), .err(err)
  );

  function automatic logic [7:0] init_val(input int a);
    return 8'(a) ^ 8'h5A;
  endfunction

  assign reg_rd_data = bank[reg_addr];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 128; i++) bank[i] <= init_val(i);
    end else begin
      if (reg_wr_en) begin
        bank[reg_addr] <= reg_wr_data;
        wr_cnt    <= wr_cnt + 1;
        last_addr <= reg_addr;
        last_data <= reg_wr_data;
      end
      if (reg_rd_en) rd_cnt <= rd_cnt + 1;
    end
  end

  always @(negedge clk) begin
    if (in_wr && sdo_oe) oe_bad <= 1'b1;
    if (sdo_oe && prev_oe && sdo !== prev_sdo && sck) edge_bad <= 1'b1;
    prev_sdo <= sdo;
    prev_oe  <= sdo_oe;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic frame(input logic [7:0] b0, input logic [7:0] b1, input int nbits,
                       output logic [7:0] rx, output logic oe_all);
    rx = '0;
    oe_all = 1'b1;
    @(negedge clk);
    scs_n = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      sdi = (i < 8) ? b0[7-i] : ((i < 16) ? b1[15-i] : 1'b1);
      repeat (HALF) @(negedge clk);
      if (i >= 8 && i < 16) begin
        rx[15-i] = sdo;
        oe_all   = oe_all & sdo_oe;
      end
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    scs_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic wr(input logic [6:0] a, input logic [7:0] d, input int nbits);
    logic [7:0] rx;
    logic oe;
    in_wr = 1'b1;
    frame({1'b0, a}, d, nbits, rx, oe);
    in_wr = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, input logic [7:0] fill,
                    output logic [7:0] rx, output logic oe);
    frame({1'b1, a}, fill, 16, rx, oe);
  endtask

  task automatic pulse_tick();
    @(negedge clk);
    slow_tick = 1'b1;
    @(negedge clk);
    slow_tick = 1'b0;
  endtask

  task automatic wait_idle();
    repeat (3) pulse_tick();
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 busy", busy, 0);
    chk("R1 err", err, 0);
    chk("R1 sdo_oe", sdo_oe, 0);
    chk("R1 strobes", {reg_wr_en, reg_rd_en}, 0);
  endtask

  task automatic t_write_read();
    logic [7:0] rx;
    logic oe;
    int w0, r0;
    w0 = wr_cnt;
    wr(7'h12, 8'hA5, 16);
    chk("R2 one write", wr_cnt - w0, 1);
    chk("R2 addr", last_addr, 7'h12);
    chk("R2 data", last_data, 8'hA5);
    chk("R5 no oe in write", oe_bad, 0);
    chk("R7 busy after write", busy, 1);
    wait_idle();
    r0 = rd_cnt;
    rd(7'h12, 8'h00, rx, oe);
    chk("R4 read data", rx, 8'hA5);
    chk("R4 oe in data", oe, 1);
    chk("R4 one strobe", rd_cnt - r0, 1);
    chk("R3 sdo edge", edge_bad, 0);
    chk("R5 oe off after", sdo_oe, 0);
  endtask

  task automatic t_sdi_ignored();
    logic [7:0] ra, rb;
    logic oa, ob;
    int w0;
    w0 = wr_cnt;
    rd(7'h12, 8'hFF, ra, oa);
    rd(7'h12, 8'h00, rb, ob);
    chk("R4 sdi ones", ra, 8'hA5);
    chk("R4 sdi zeros", rb, 8'hA5);
    chk("R4 no write", wr_cnt - w0, 0);
  endtask

  task automatic t_abort();
    logic [7:0] rx;
    logic oe;
    int w0;
    w0 = wr_cnt;
    wr(7'h20, 8'h3C, 13);
    chk("R6 no write", wr_cnt - w0, 0);
    chk("R6 no busy", busy, 0);
    rd(7'h20, 8'h00, rx, oe);
    chk("R6 reg intact", rx, init_val(32));
  endtask

  task automatic t_extra();
    int w0;
    w0 = wr_cnt;
    wr(7'h21, 8'h77, 20);
    chk("R10 one write", wr_cnt - w0, 1);
    chk("R10 first byte", last_data, 8'h77);
    wait_idle();
  endtask

  task automatic t_busy_timing();
    wr(7'h30, 8'h01, 16);
    chk("R7 busy set", busy, 1);
    pulse_tick();
    chk("R7 busy tick1", busy, 1);
    pulse_tick();
    chk("R7 busy tick2", busy, 1);
    pulse_tick();
    chk("R7 busy clear tick3", busy, 0);
  endtask

  task automatic t_drop();
    logic [7:0] rx;
    logic oe;
    int w0, r0;
    wr(7'h31, 8'h55, 16);
    r0 = rd_cnt;
    rd(7'h31, 8'h00, rx, oe);
    chk("R8 read dropped", rd_cnt - r0, 0);
    chk("R8 no oe", oe, 0);
    chk("R8 err set", err, 1);
    w0 = wr_cnt;
    wr(7'h32, 8'h66, 16);
    chk("R8 write dropped", wr_cnt - w0, 0);
    wait_idle();
    rd(7'h31, 8'h00, rx, oe);
    chk("R8 first write kept", rx, 8'h55);
    rd(7'h32, 8'h00, rx, oe);
    chk("R8 dropped reg intact", rx, init_val(50));
    chk("R9 err sticky", err, 1);
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_write_read();
    t_sdi_ignored();
    t_abort();
    t_extra();
    t_busy_timing();
    t_drop();
    summary();
  end
endmodule